// File: doc/BRIEF.md
# Triggered Lighting Timer Controller

This block is the decision logic behind a retriggerable lamp timer used for motion-detector and staircase lighting. It watches two sensor levels that have already been compared in the analog domain: a light-enable level (dark enough to switch on) and a motion level (the sensor output sits outside its quiet window). It qualifies both against noise, combines them into a trigger, and times a tracking interval. During that interval the output stage is kept on. Every switching point is taken at a mains zero crossing.

Three programmable behaviours are supported. The first is a static zero-voltage switch. The second is a two-stage phase control that ends at expiry. The third is a two-stage phase control in which the light-enable level alone can hold the lamp at the set angle. The outputs tell a downstream phase sequencer whether to run, whether to use the maximum or the set conduction angle, and whether to hold a static on-state instead. After a switch-off, a lockout keeps the lamp's own switching transient from retriggering it. Power-up runs one demonstration cycle. An over-temperature event shuts the output down until power is cycled.

Top module: `lamp_timer_ctrl`

## Requirements
- R1: A trigger needs the qualified light-enable level and the qualified motion level at the same time. Either one alone, in the two timing modes (mode 01 and mode 10), never starts an operating cycle.
- R2: An input level counts as qualified only after it has stayed high across QUAL_MS pulses of msTick. It drops out at once when the raw level goes low, so a pulse covering fewer msTick pulses is ignored.
- R3: Each switch-off of the load loads a lockout of LOCK_MS msTick pulses. While the lockout runs, no trigger and no light-only hold is accepted.
- R4: The tracking interval is 2^DIV_BITS pulses of tick, counted from the zero crossing that switches the load on.
- R5: In modes 00 and 10, useMaxAngle is high together with run from switch-on until 3/4 of the tracking interval has elapsed. After that point run stays high and useMaxAngle is low.
- R6: In mode 01, staticOn rises at the first zero crossing after a trigger. It falls at the first zero crossing after the tracking interval expires. run and useMaxAngle stay low in this mode.
- R7: In mode 10, once the tracking interval expires the output stays on until the next zero crossing and then switches off, even while the light-enable level is high.
- R8: In mode 00, a trigger during the on phase restarts the tracking interval from zero. If the interval ends while light-enable is still qualified, or if light-enable alone is qualified at a zero crossing while idle, the output holds at the set angle (run high, useMaxAngle low). The hold ends at the first zero crossing after light-enable drops.
- R9: After powerGood first asserts, one full operating cycle starts at the next zero crossing, whatever the sensor levels are.
- R10: overTemp asserted while powerGood is high turns all outputs off from the next cycle. The off state persists regardless of inputs until powerGood is removed and then restored.
- R11: The mode is encoded as 00 = two-stage with light-only hold, 01 = static zero-voltage switch, 10 = two-stage with switch-off at expiry, and 11 = behaves as 00. The mode is captured at switch-on, and later changes of the mode pins do not affect the running cycle.
- R12: During reset and while powerGood is low, run, useMaxAngle and staticOn are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the base oscillator that advances the tracking count |
| msTick | input | 1 | One-cycle millisecond strobe that times qualification and lockout |
| zeroCross | input | 1 | One-cycle strobe at each detected mains zero crossing |
| lightEn | input | 1 | Light-enable comparator level, high = dark enough |
| motion | input | 1 | Motion window comparator level, high = trigger |
| mode | input | 2 | Operating mode select (see R11) |
| powerGood | input | 1 | Supply has reached the operating threshold |
| overTemp | input | 1 | Chip over-temperature flag |
| run | output | 1 | Phase sequencer enable |
| useMaxAngle | output | 1 | Select the maximum conduction angle instead of the set angle |
| staticOn | output | 1 | Hold the output statically on (zero-voltage-switch mode) |

## Verification
The hardest case to reach from the ports is a retrigger in the middle of a tracking interval. The two sensor levels need QUAL_MS millisecond strobes to qualify, and while they are qualifying the interval would simply run out. The bench therefore holds tick low during the second qualification, which freezes the tracking count at a known value. When the count afterwards reaches its 3/4 mark later than a frozen count would allow, the restart has taken place. The lockout window is reached the same way: the qualification counters run alongside the lockout count, so the bench places its zero crossing one msTick before the lockout ends.

// File: rtl/lamp_timer_pkg.sv
package lamp_timer_pkg;

  typedef enum logic [1:0] {
    MODE_TWO   = 2'b00,
    MODE_ZVS   = 2'b01,
    MODE_SWOFF = 2'b10
  } lampMode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_ON    = 3'd2,
    ST_DRAIN = 3'd3,
    ST_HOLD  = 3'd4,
    ST_FAULT = 3'd5
  } lampState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic trackClr;
    logic trackRun;
    logic lockLoad;
    logic lockClr;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lightQ;
    logic motionQ;
    logic lockActive;
    logic late;
    logic expired;
  } dpStatus_t;

  function automatic lampMode_e normMode(input logic [1:0] raw);
    case (raw)
      2'b01:   return MODE_ZVS;
      2'b10:   return MODE_SWOFF;
      default: return MODE_TWO;
    endcase
  endfunction

endpackage

// File: rtl/lamp_timer_qual.sv
module lamp_timer_qual #(
  parameter int QUAL_MS = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic rawIn,
  output logic qualOut
);
  localparam int QW = $clog2(QUAL_MS + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_MS);

  logic [QW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !rawIn) begin
      holdCnt <= '0;
    end else if (msTick && holdCnt != QMAX) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign qualOut = rawIn && (holdCnt == QMAX);
endmodule

// File: rtl/lamp_timer_datapath.sv
module lamp_timer_datapath
  import lamp_timer_pkg::*;
#(
  parameter int DIV_BITS = 11,
  parameter int QUAL_MS  = 40,
  parameter int LOCK_MS  = 640
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        msTick,
  input  logic        lightEn,
  input  logic        motion,
  input  ctrlStrobe_t strb,
  output dpStatus_t   stat
);
  localparam int TW = DIV_BITS + 1;
  localparam logic [TW-1:0] FULL = TW'(1) << DIV_BITS;
  localparam logic [TW-1:0] LATE = TW'(3) << (DIV_BITS - 2);
  localparam int LW = $clog2(LOCK_MS + 1);
  localparam logic [LW-1:0] LMAX = LW'(LOCK_MS);

  logic [1:0]    rawLvl;
  logic [1:0]    qualLvl;
  logic [TW-1:0] trackCnt;
  logic [LW-1:0] lockCnt;

  assign rawLvl = {motion, lightEn};

  for (genvar i = 0; i < 2; i++) begin : gQual
    lamp_timer_qual #(.QUAL_MS(QUAL_MS)) uQual (
      .clk    (clk),
      .rstN   (rstN),
      .msTick (msTick),
      .rawIn  (rawLvl[i]),
      .qualOut(qualLvl[i])
    );
  end

  // tracking interval counter, saturates at FULL
  always_ff @(posedge clk) begin
    if (!rstN || strb.trackClr) begin
      trackCnt <= '0;
    end else if (strb.trackRun && tick && trackCnt != FULL) begin
      trackCnt <= trackCnt + 1'b1;
    end
  end

  // retrigger lockout after switch-off
  always_ff @(posedge clk) begin
    if (!rstN || strb.lockClr) begin
      lockCnt <= '0;
    end else if (strb.lockLoad) begin
      lockCnt <= LMAX;
    end else if (msTick && lockCnt != '0) begin
      lockCnt <= lockCnt - 1'b1;
    end
  end

  assign stat.lightQ     = qualLvl[0];
  assign stat.motionQ    = qualLvl[1];
  assign stat.lockActive = (lockCnt != '0);
  assign stat.late       = (trackCnt >= LATE);
  assign stat.expired    = (trackCnt == FULL);
endmodule

// File: rtl/lamp_timer_control.sv
module lamp_timer_control
  import lamp_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        zeroCross,
  input  logic [1:0]  mode,
  input  logic        powerGood,
  input  logic        overTemp,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        run,
  output logic        useMaxAngle,
  output logic        staticOn
);
  lampState_e state, nxt;
  lampMode_e  activeMode;
  logic       pgPrev;
  logic       captureMode;
  logic       trig;
  logic       loadOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pgPrev     <= 1'b0;
      activeMode <= MODE_TWO;
    end else begin
      state  <= nxt;
      pgPrev <= powerGood;
      if (captureMode) activeMode <= normMode(mode);
    end
  end

  assign trig = stat.lightQ && stat.motionQ && !stat.lockActive;

  always_comb begin
    nxt         = state;
    strb        = '0;
    captureMode = 1'b0;
    if (!powerGood) begin
      nxt          = ST_IDLE;
      strb.lockClr = 1'b1;
    end else if (overTemp || state == ST_FAULT) begin
      nxt = ST_FAULT;
    end else if (!pgPrev) begin
      nxt = ST_ARM;  // power-up demonstration cycle
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            nxt = ST_ARM;
          end else if (normMode(mode) == MODE_TWO && stat.lightQ &&
                       !stat.lockActive && zeroCross) begin
            nxt         = ST_HOLD;
            captureMode = 1'b1;
          end
        end
        ST_ARM: begin
          if (zeroCross) begin
            nxt           = ST_ON;
            strb.trackClr = 1'b1;
            captureMode   = 1'b1;
          end
        end
        ST_ON: begin
          if (trig) begin
            strb.trackClr = 1'b1;
          end else if (stat.expired) begin
            nxt = (activeMode == MODE_TWO && stat.lightQ) ? ST_HOLD : ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (zeroCross) begin
            nxt           = ST_IDLE;
            strb.lockLoad = 1'b1;
          end
        end
        ST_HOLD: begin
          if (trig) begin
            nxt           = ST_ON;
            strb.trackClr = 1'b1;
          end else if (!stat.lightQ && zeroCross) begin
            nxt           = ST_IDLE;
            strb.lockLoad = 1'b1;
          end
        end
        default: nxt = state;
      endcase
    end
    strb.trackRun = (state == ST_ON);
  end

  assign loadOn      = (state == ST_ON) || (state == ST_DRAIN);
  assign staticOn    = loadOn && activeMode == MODE_ZVS;
  assign run         = (loadOn && activeMode != MODE_ZVS) || state == ST_HOLD;
  assign useMaxAngle = state == ST_ON && activeMode != MODE_ZVS && !stat.late;
endmodule

// File: rtl/lamp_timer_ctrl.sv
module lamp_timer_ctrl
  import lamp_timer_pkg::*;
#(
  parameter int DIV_BITS = 11,
  parameter int QUAL_MS  = 40,
  parameter int LOCK_MS  = 640
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       msTick,
  input  logic       zeroCross,
  input  logic       lightEn,
  input  logic       motion,
  input  logic [1:0] mode,
  input  logic       powerGood,
  input  logic       overTemp,
  output logic       run,
  output logic       useMaxAngle,
  output logic       staticOn
);
  ctrlStrobe_t strb;
  dpStatus_t   stat;

  lamp_timer_datapath #(
    .DIV_BITS(DIV_BITS),
    .QUAL_MS (QUAL_MS),
    .LOCK_MS (LOCK_MS)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .msTick (msTick),
    .lightEn(lightEn),
    .motion (motion),
    .strb   (strb),
    .stat   (stat)
  );

  lamp_timer_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .zeroCross  (zeroCross),
    .mode       (mode),
    .powerGood  (powerGood),
    .overTemp   (overTemp),
    .stat       (stat),
    .strb       (strb),
    .run        (run),
    .useMaxAngle(useMaxAngle),
    .staticOn   (staticOn)
  );
endmodule

// File: rtl/lamp_timer_chk.sv
module lamp_timer_chk (
  input logic clk,
  input logic rstN,
  input logic zeroCross,
  input logic powerGood,
  input logic overTemp,
  input logic run,
  input logic useMaxAngle,
  input logic staticOn
);
  // R6
  static_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(run && staticOn));

  // R5
  max_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    useMaxAngle |-> run);

  // R6
  static_on_at_zc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(staticOn) |-> $past(zeroCross));

  // R8
  run_on_at_zc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> $past(zeroCross));

  // R10
  hot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overTemp && powerGood) |=> (!run && !staticOn));

  // R12
  no_power_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> (!run && !staticOn && !useMaxAngle));
endmodule

bind lamp_timer_ctrl lamp_timer_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .zeroCross  (zeroCross),
  .powerGood  (powerGood),
  .overTemp   (overTemp),
  .run        (run),
  .useMaxAngle(useMaxAngle),
  .staticOn   (staticOn)
);

// File: tb/lamp_timer_ctrl_test.sv
module lamp_timer_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 4;
  localparam int LOCK = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic msTick = 1'b0;
  logic zeroCross = 1'b0;
  logic lightEn = 1'b0;
  logic motion = 1'b0;
  logic [1:0] mode = 2'b01;
  logic powerGood = 1'b0;
  logic overTemp = 1'b0;
  logic run, useMaxAngle, staticOn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lamp_timer_ctrl #(.DIV_BITS(4), .QUAL_MS(QUAL), .LOCK_MS(LOCK)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .msTick(msTick),
    .zeroCross(zeroCross), .lightEn(lightEn), .motion(motion), .mode(mode),
    .powerGood(powerGood), .overTemp(overTemp),
    .run(run), .useMaxAngle(useMaxAngle), .staticOn(staticOn)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic msPulse(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1; @(negedge clk);
      msTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic zc();
    zeroCross = 1'b1; @(negedge clk);
    zeroCross = 1'b0;
  endtask

  // expected order {run, useMaxAngle, staticOn}
  task automatic expect3(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {run, useMaxAngle, staticOn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: run/max/static actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic testReset();
    step(3);
    expect3("R12 reset", 3'b000);
    rstN = 1'b1;
    step(3);
    expect3("R12 no power", 3'b000);
  endtask

  task automatic testPowerUpZvs();
    powerGood = 1'b1;
    step(4);
    expect3("R6 no output before zero crossing", 3'b000);
    zc();
    expect3("R9 power-up cycle static on", 3'b001);
    step(20);
    expect3("R6 static held until zero crossing", 3'b001);
    zc();
    expect3("R6 static off at zero crossing", 3'b000);
  endtask

  task automatic testLockoutSwoff();
    mode = 2'b10; lightEn = 1'b1; motion = 1'b1;
    msPulse(LOCK - 1);
    zc();
    expect3("R3 lockout blocks trigger", 3'b000);
    msPulse(1);
    zc();
    expect3("R3 trigger after lockout", 3'b110);
    motion = 1'b0; mode = 2'b01;
    step(11);
    expect3("R11 mode captured, R5 max angle", 3'b110);
    step(1);
    expect3("R4 R5 set angle at 3/4", 3'b100);
    step(8);
    expect3("R7 on until zero crossing", 3'b100);
    zc();
    expect3("R7 off at zero crossing", 3'b000);
  endtask

  task automatic testRetriggerHold();
    mode = 2'b00; motion = 1'b1;
    msPulse(LOCK);
    zc();
    expect3("R1 both qualified starts", 3'b110);
    motion = 1'b0;
    step(8);
    tick = 1'b0; motion = 1'b1;
    msPulse(QUAL);
    motion = 1'b0; tick = 1'b1;
    step(11);
    expect3("R8 retrigger restarts interval", 3'b110);
    step(1);
    expect3("R5 set angle after restart", 3'b100);
    step(6);
    zc();
    expect3("R8 light holds at set angle", 3'b100);
    lightEn = 1'b0;
    step(2);
    expect3("R8 hold until zero crossing", 3'b100);
    zc();
    expect3("R8 off after light drops", 3'b000);
  endtask

  task automatic testLightOnly();
    mode = 2'b11; lightEn = 1'b1;
    msPulse(LOCK);
    expect3("R8 light-only waits zero crossing", 3'b000);
    zc();
    expect3("R11 mode 11 light-only hold", 3'b100);
    step(5);
    lightEn = 1'b0;
    zc();
    expect3("R8 light-only hold ends", 3'b000);
  endtask

  task automatic testNoiseAnd();
    mode = 2'b10; lightEn = 1'b1;
    msPulse(LOCK);
    motion = 1'b1;
    msPulse(QUAL - 1);
    motion = 1'b0;
    step(2);
    zc();
    expect3("R2 short motion ignored", 3'b000);
    lightEn = 1'b0; motion = 1'b1;
    msPulse(QUAL + 2);
    zc();
    expect3("R1 motion alone ignored", 3'b000);
    lightEn = 1'b1;
    msPulse(QUAL);
    zc();
    expect3("R2 qualified after full time", 3'b110);
    lightEn = 1'b0; motion = 1'b0;
  endtask

  task automatic testOverTemp();
    step(2);
    overTemp = 1'b1;
    step(1);
    overTemp = 1'b0;
    expect3("R10 output off on over-temp", 3'b000);
    lightEn = 1'b1; motion = 1'b1;
    msPulse(LOCK + 1);
    zc();
    expect3("R10 latched off", 3'b000);
    lightEn = 1'b0; motion = 1'b0;
    powerGood = 1'b0;
    step(2);
    expect3("R12 off without power", 3'b000);
    powerGood = 1'b1;
    step(1);
    zc();
    expect3("R10 R9 restart after power cycle", 3'b110);
  endtask

  initial begin
    testReset();
    testPowerUpZvs();
    testLockoutSwoff();
    testRetriggerHold();
    testLightOnly();
    testNoiseAnd();
    testOverTemp();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule